// File: doc/BRIEF.md
# Multi-Writer Memory with Collision Scrambling

This block is a small synchronous memory with a single combinational read port and several write ports (three by default). Each writer brings its own enable, address, data word and byte mask. When writers collide, the block does not pick a silent winner. It treats the collision as producing an undefined value and models that value explicitly with pseudo-random data.

Two writers collide when both are enabled in the same cycle and present equal addresses. The writers are ranked by index, and writer 0 ranks first. A lower-index writer in a colliding pair stores a word taken from its own pseudo-random generator in place of its data. Any writer that collides with a lower-index writer has its write suppressed.

A design parameter can declare chosen writer pairs as never active together. The comparison for such a pair is left out entirely. Integrators use the block to expose code that depends on colliding writes, because the stored value is deliberately unpredictable yet reproducible from the seed.

Top module: `conflict_wmem`

## Requirements
- R1: While `rst_n` is low at a clock edge, every memory entry is cleared to zero. At the same edge, the generator of writer k loads `seed ^ (k * 32'h9E3779B9)`, and loads 1 instead if that value is zero.
- R2: Writers j and i collide when both enables are high and both addresses are equal. A writer that collides with any lower-index writer stores nothing in that cycle.
- R3: A writer that collides with any higher-index writer stores the current word of its own generator in place of its data word.
- R4: A generator steps only in a cycle where its writer substitutes data. A step shifts the word right by one bit and XORs in 32'h80200003 when the bit shifted out was 1. The generator word is never zero.
- R5: A pair (i, j) with i < j whose bit i*NW+j is set in `EXCL_PAIRS` is never compared. If both writers in such a pair still hit the same address, neither is gated and neither substitutes. Both writes proceed, and the higher-index writer's bytes land last.
- R6: Bit b of a writer's mask enables byte b (bits 8b+7..8b) of that writer's surviving write, including a substituted random word. A writer whose mask is all zero still counts in collision detection.
- R7: A write becomes visible on `rd_data` after the clock edge that captures it and not before. `rd_data` follows `rd_addr` combinationally.
- R8: Enabled writers at distinct addresses all store their own data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed | input | DW (32) | Generator seed, loaded during reset |
| wr_en | input | NW (3) | Per-writer write enable |
| wr_addr | input | NW x AW (3x5) | Per-writer address |
| wr_data | input | NW x DW (3x32) | Per-writer data word |
| wr_mask | input | NW x MW (3x4) | Per-writer byte enables |
| rd_addr | input | AW (5) | Read address |
| rd_data | output | DW (32) | Read data, combinational |

## Verification
The bench drives a single writer, writers at distinct addresses, each of the three collision pairs alone, a three-way collision, and mixed cases where one pair collides while a third writer goes elsewhere. Together these show that gating, substitution and ordinary writes are separate effects. Two instances receive the same stimulus, one with all pairs compared and one with the 0-2 pair omitted. Any difference between them on the 0-2 collision therefore isolates the omission. Masked collisions, including one whose lower-index writer has an empty mask, separate mask application from collision detection. A second reset followed by a collision shows that the generators reload from the seed.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  localparam int          CWM_NW       = 3;
  localparam int          CWM_DEPTH    = 32;
  localparam int          CWM_DW       = 32;
  localparam logic [31:0] CWM_POLY     = 32'h80200003;
  localparam logic [31:0] CWM_SEED_MIX = 32'h9E3779B9;
endpackage

// File: rtl/cwm_pair_detect.sv
module cwm_pair_detect #(
  parameter int NW = cwm_pkg::CWM_NW,
  parameter int AW = 5,
  parameter logic [NW*NW-1:0] EXCL_PAIRS = '0
) (
  input  logic [NW-1:0]         en,
  input  logic [NW-1:0][AW-1:0] addr,
  output logic [NW*NW-1:0]      pair_hit,
  output logic [NW-1:0]         win_en,
  output logic [NW-1:0]         draw
);
  function automatic logic hit_of(input logic ea, input logic eb,
                                  input logic [AW-1:0] aa, input logic [AW-1:0] ab);
    return ea & eb & (aa == ab);
  endfunction

  for (genvar i = 0; i < NW; i++) begin : g_row
    for (genvar j = 0; j < NW; j++) begin : g_col
      if (j > i && !EXCL_PAIRS[i*NW+j]) begin : g_cmp
        assign pair_hit[i*NW+j] = hit_of(en[i], en[j], addr[i], addr[j]);
      end else begin : g_none
        assign pair_hit[i*NW+j] = 1'b0;
      end
    end
  end

  logic [NW-1:0] blocked;

  always_comb begin
    draw    = '0;
    blocked = '0;
    for (int i = 0; i < NW; i++) begin
      for (int j = 0; j < NW; j++) begin
        draw[i]    = draw[i]    | pair_hit[i*NW+j];
        blocked[i] = blocked[i] | pair_hit[j*NW+i];
      end
    end
    win_en = en & ~blocked;
  end
endmodule

// File: rtl/cwm_lfsr.sv
module cwm_lfsr #(
  parameter int DW = cwm_pkg::CWM_DW,
  parameter logic [DW-1:0] POLY = DW'(cwm_pkg::CWM_POLY),
  parameter logic [DW-1:0] MIX  = DW'(cwm_pkg::CWM_SEED_MIX),
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] seed,
  input  logic          step,
  output logic [DW-1:0] state
);
  function automatic logic [DW-1:0] advance(input logic [DW-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY : '0);
  endfunction

  function automatic logic [DW-1:0] load_value(input logic [DW-1:0] sd);
    logic [DW-1:0] v;
    v = sd ^ (DW'(IDX) * MIX);
    return (v == '0) ? DW'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= load_value(seed);
    else if (step) state <= advance(state);
  end
endmodule

// File: rtl/cwm_array.sv
module cwm_array #(
  parameter int NW    = cwm_pkg::CWM_NW,
  parameter int DEPTH = cwm_pkg::CWM_DEPTH,
  parameter int DW    = cwm_pkg::CWM_DW,
  parameter int AW    = $clog2(DEPTH),
  parameter int MW    = DW / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NW-1:0]         we,
  input  logic [NW-1:0][AW-1:0] waddr,
  input  logic [NW-1:0][DW-1:0] wdata,
  input  logic [NW-1:0][MW-1:0] wmask,
  input  logic [AW-1:0]         raddr,
  output logic [DW-1:0]         rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int k = 0; k < NW; k++) begin
        for (int b = 0; b < MW; b++) begin
          if (we[k] && wmask[k][b]) mem[waddr[k]][b*8 +: 8] <= wdata[k][b*8 +: 8];
        end
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/conflict_wmem.sv
module conflict_wmem #(
  parameter int NW    = cwm_pkg::CWM_NW,
  parameter int DEPTH = cwm_pkg::CWM_DEPTH,
  parameter int DW    = cwm_pkg::CWM_DW,
  parameter int AW    = $clog2(DEPTH),
  parameter int MW    = DW / 8,
  parameter logic [NW*NW-1:0] EXCL_PAIRS = '0,
  parameter logic [DW-1:0] POLY = DW'(cwm_pkg::CWM_POLY)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         seed,
  input  logic [NW-1:0]         wr_en,
  input  logic [NW-1:0][AW-1:0] wr_addr,
  input  logic [NW-1:0][DW-1:0] wr_data,
  input  logic [NW-1:0][MW-1:0] wr_mask,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data
);
  logic [NW*NW-1:0]      pair_hit;
  logic [NW-1:0]         win_en;
  logic [NW-1:0]         draw;
  logic [NW-1:0][DW-1:0] lfsr_q;
  logic [NW-1:0][DW-1:0] wr_word;

  cwm_pair_detect #(.NW(NW), .AW(AW), .EXCL_PAIRS(EXCL_PAIRS)) u_detect (
    .en(wr_en), .addr(wr_addr), .pair_hit(pair_hit), .win_en(win_en), .draw(draw)
  );

  for (genvar k = 0; k < NW; k++) begin : g_wr
    cwm_lfsr #(.DW(DW), .POLY(POLY), .IDX(k)) u_rng (
      .clk(clk), .rst_n(rst_n), .seed(seed), .step(draw[k]), .state(lfsr_q[k])
    );
    assign wr_word[k] = draw[k] ? lfsr_q[k] : wr_data[k];
  end

  cwm_array #(.NW(NW), .DEPTH(DEPTH), .DW(DW), .AW(AW), .MW(MW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(win_en), .waddr(wr_addr), .wdata(wr_word),
    .wmask(wr_mask), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/conflict_wmem_chk.sv
module conflict_wmem_chk #(
  parameter int NW = cwm_pkg::CWM_NW,
  parameter int DW = cwm_pkg::CWM_DW,
  parameter logic [NW*NW-1:0] EXCL_PAIRS = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NW-1:0]         wr_en,
  input logic [NW*NW-1:0]      pair_hit,
  input logic [NW-1:0]         win_en,
  input logic [NW-1:0]         draw,
  input logic [NW-1:0][DW-1:0] lfsr_q
);
  // R2: a surviving write always had its enable raised
  p_win_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en & ~wr_en) == '0);

  for (genvar i = 0; i < NW; i++) begin : g_i
    for (genvar j = i + 1; j < NW; j++) begin : g_j
      if (!EXCL_PAIRS[i*NW+j]) begin : g_on
        // R2: the higher-index writer of a colliding pair is suppressed
        p_gate_later_r2: assert property (@(posedge clk) disable iff (!rst_n)
          pair_hit[i*NW+j] |-> !win_en[j]);
        // R3: the lower-index writer of a colliding pair substitutes
        p_first_draws_r3: assert property (@(posedge clk) disable iff (!rst_n)
          pair_hit[i*NW+j] |-> draw[i]);
      end
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_k
    // R4: generator holds without a draw
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !draw[k] |=> $stable(lfsr_q[k]));
    // R4: generator moves on a draw
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      draw[k] |=> lfsr_q[k] != $past(lfsr_q[k]));
    // R4: generator never zero
    p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q[k] != '0);
  end
endmodule

bind conflict_wmem conflict_wmem_chk #(.NW(NW), .DW(DW), .EXCL_PAIRS(EXCL_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pair_hit(pair_hit),
  .win_en(win_en), .draw(draw), .lfsr_q(lfsr_q)
);

// File: tb/conflict_wmem_bench.sv
`timescale 1ns/1ps
module conflict_wmem_bench;
  localparam int NV = 13;
  // fields: en[29:27] a0[26:22] a1[21:17] a2[16:12] m0[11:8] m1[7:4] m2[3:0]
  localparam logic [29:0] VEC [NV] = '{
    {3'b001, 5'd3,  5'd0,  5'd0,  4'hF, 4'hF, 4'hF},
    {3'b110, 5'd0,  5'd4,  5'd5,  4'hF, 4'hF, 4'hF},
    {3'b011, 5'd7,  5'd7,  5'd0,  4'hF, 4'hF, 4'hF},
    {3'b101, 5'd8,  5'd0,  5'd8,  4'hF, 4'hF, 4'hF},
    {3'b110, 5'd0,  5'd9,  5'd9,  4'hF, 4'hF, 4'hF},
    {3'b111, 5'd10, 5'd10, 5'd10, 4'hF, 4'hF, 4'hF},
    {3'b111, 5'd11, 5'd11, 5'd12, 4'hF, 4'hF, 4'hF},
    {3'b011, 5'd13, 5'd13, 5'd0,  4'h3, 4'hF, 4'hF},
    {3'b110, 5'd0,  5'd14, 5'd14, 4'hF, 4'h0, 4'hF},
    {3'b111, 5'd15, 5'd16, 5'd15, 4'hF, 4'hF, 4'hF},
    {3'b000, 5'd3,  5'd4,  5'd5,  4'hF, 4'hF, 4'hF},
    {3'b001, 5'd3,  5'd0,  5'd0,  4'hC, 4'hF, 4'hF},
    {3'b101, 5'd17, 5'd0,  5'd17, 4'h0, 4'hF, 4'hF}
  };
  localparam string TAG [NV] = '{
    "R8 single", "R8 distinct", "R2 R3 pair01", "R2 R3 R5 pair02", "R2 R3 pair12",
    "R2 R3 triple", "R2 R3 R8 mixed", "R6 masked random", "R6 empty mask counts",
    "R2 R3 R5 pair02 plus b", "R8 idle", "R6 partial overwrite", "R5 R6 empty mask pair02"
  };
  localparam logic [8:0] XM [2] = '{9'd0, 9'b000000100};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] seed = 32'h1357_9BDF;
  logic [2:0] wen = '0;
  logic [2:0][4:0] waddr = '0;
  logic [2:0][31:0] wdata = '0;
  logic [2:0][3:0] wmask = '0;
  logic [4:0] raddr = '0;
  logic [31:0] rdata0, rdata1;
  int checks = 0;
  int errors = 0;
  logic [31:0] rm [2][32];
  logic [31:0] rl [2][3];

  always #10 clk = ~clk;

  conflict_wmem u_conflict_wmem (
    .clk(clk), .rst_n(rst_n), .seed(seed), .wr_en(wen), .wr_addr(waddr),
    .wr_data(wdata), .wr_mask(wmask), .rd_addr(raddr), .rd_data(rdata0)
  );
  conflict_wmem #(.EXCL_PAIRS(9'b000000100)) u_conflict_wmem_x (
    .clk(clk), .rst_n(rst_n), .seed(seed), .wr_en(wen), .wr_addr(waddr),
    .wr_data(wdata), .wr_mask(wmask), .rd_addr(raddr), .rd_data(rdata1)
  );

  function automatic logic [31:0] b_step(input logic [31:0] s);
    logic [31:0] n;
    n = {1'b0, s[31:1]};
    if (s[0]) n = n ^ 32'h80200003;
    return n;
  endfunction

  function automatic logic [31:0] b_seed(input logic [31:0] sd, input int k);
    logic [31:0] v;
    v = sd ^ (32'(k) * 32'h9E3779B9);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < 2; n++) begin
      for (int a = 0; a < 32; a++) rm[n][a] = '0;
      for (int k = 0; k < 3; k++) rl[n][k] = b_seed(seed, k);
    end
  endtask

  task automatic model_write();
    logic [31:0] w [3];
    bit go [3];
    bit rnd [3];
    for (int n = 0; n < 2; n++) begin
      for (int k = 0; k < 3; k++) begin
        go[k] = wen[k];
        rnd[k] = 1'b0;
        for (int i = 0; i < 3; i++) begin
          if (i != k && wen[k] && wen[i] && waddr[i] == waddr[k]) begin
            if (i < k && !XM[n][i*3+k]) go[k] = 1'b0;
            if (i > k && !XM[n][k*3+i]) rnd[k] = 1'b1;
          end
        end
        w[k] = rnd[k] ? rl[n][k] : wdata[k];
      end
      for (int k = 0; k < 3; k++)
        if (go[k])
          for (int b = 0; b < 4; b++)
            if (wmask[k][b]) rm[n][waddr[k]][b*8 +: 8] = w[k][b*8 +: 8];
      for (int k = 0; k < 3; k++) if (rnd[k]) rl[n][k] = b_step(rl[n][k]);
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic readback(input logic [4:0] a, input string tag);
    raddr = a;
    #1;
    chk(rdata0, rm[0][a], {tag, " all-pairs"});
    chk(rdata1, rm[1][a], {tag, " omitted-02"});
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    readback(5'd0, "R1 reset");
    readback(5'd31, "R1 reset");

    // R7: not visible before the edge, visible after
    @(negedge clk);
    wen = 3'b001; waddr[0] = 5'd2; wdata[0] = 32'hA5A5_0202; wmask[0] = 4'hF; raddr = 5'd2;
    #1;
    chk(rdata0, 32'd0, "R7 before edge");
    model_write();
    @(posedge clk);
    @(negedge clk) wen = '0;
    readback(5'd2, "R7 after edge");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wen = VEC[v][29:27];
      waddr[0] = VEC[v][26:22]; waddr[1] = VEC[v][21:17]; waddr[2] = VEC[v][16:12];
      wmask[0] = VEC[v][11:8];  wmask[1] = VEC[v][7:4];   wmask[2] = VEC[v][3:0];
      for (int k = 0; k < 3; k++) wdata[k] = 32'hC0DE_0000 | (32'(v) << 8) | 32'(k);
      model_write();
      @(posedge clk);
      @(negedge clk) wen = '0;
      for (int k = 0; k < 3; k++) readback(waddr[k], TAG[v]);
    end

    // R1: second reset clears and reloads generators from seed
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    readback(5'd3, "R1 reload clear");
    rst_n = 1'b1;
    wen = 3'b011; waddr[0] = 5'd20; waddr[1] = 5'd20; wmask[0] = 4'hF; wmask[1] = 4'hF;
    model_write();
    @(posedge clk);
    @(negedge clk) wen = '0;
    readback(5'd20, "R1 R3 seed reload");
    chk(rdata0, b_seed(seed, 0), "R1 R3 first draw equals seed");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule